// File: doc/BRIEF.md
# Hall-Change Capture Speed Timer

This block turns the three Hall position lines of a brushless motor into a period measurement. A 16-bit counter advances on a prescaled tick taken from one of six divider taps. The block compares each sample of the 3-bit position code with the previous sample. Every difference counts as one commutation step. When the selected number of steps has been seen, the block does three things: it copies the counter into a capture register, restarts the counter from zero, and raises a one-clock interrupt.

The captured value grows as the motor slows down. A value of 1 is the fastest rotation the block can resolve and 0xFFFF is the slowest. A step span of 1 gives a reading on every commutation. A span of 3 gives one reading per half electrical turn and a span of 6 one per full electrical turn. The longer spans stretch the measurable speed range upward by the same factor. Software turns the captured value into rpm outside this block.

Top module: `hall_speed_timer`

## Requirements
- R1: After a synchronous reset, the outputs read as follows: `cap_value` is 0, and `cap_valid`, `ovf` and `irq` are all low.
- R2: `tick_sel` picks the count tick. Codes 0, 1, 2, 3, 4 and 5 select division of the system clock by 1, 4, 16, 64, 256 and 1024; codes 6 and 7 also divide by 1024. The divider restarts from zero when `en` rises, and the counter advances once per tick.
- R3: `span_sel` sets the number of position changes per capture: 2'b00 gives 1, 2'b01 gives 3, 2'b10 gives 6, and 2'b11 gives 1. A change is any cycle in which `hall_pos` differs from its value one clock earlier.
- R4: On the capture edge, `cap_value` is loaded with the counter value held just before that edge, the counter restarts from zero, and `cap_valid` goes high and stays high.
- R5: `irq` is high for exactly the one cycle that follows the edge loading `cap_value`, and is low otherwise.
- R6: The counter stops at 0xFFFF instead of wrapping. `ovf` goes high on the edge where the counter reaches 0xFFFF and stays high until a capture, or `en` low, clears it.
- R7: Any change of `span_sel` discards the position changes counted so far.
- R8: While `en` is low, the counter, the divider, the change count and `ovf` are held at zero, position changes cause no capture, and `cap_value` and `cap_valid` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Measurement enable |
| hall_pos | input | 3 | Filtered Hall position code |
| tick_sel | input | 3 | Count tick divider select |
| span_sel | input | 2 | Position changes per capture |
| cap_value | output | 16 | Last captured period count |
| cap_valid | output | 1 | At least one capture since reset |
| ovf | output | 1 | Counter saturated since last capture |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The hardest state to reach from the ports is saturation. With the undivided tick, the counter needs 65,535 enabled cycles with no position change before `ovf` rises. The stimulus therefore holds the position steady for exactly that long, checks `ovf` one cycle before and one cycle after the saturating edge, and then forces a change to confirm that 0xFFFF is captured and the flag drops. The discard of a partial change count is reached in a similar way. Two changes are made under a span of 3, `span_sel` is flipped away and back, and the test confirms that the next two changes still raise no interrupt.

// File: rtl/hst_pkg.sv
package hst_pkg;

    localparam int CNT_W = 16;
    localparam int DIV_W = 10;
    localparam int POS_W = 3;
    localparam int CHG_W = 3;
    localparam int TSEL_W = 3;
    localparam int SSEL_W = 2;

    typedef struct packed {
        logic             fire;
        logic [CNT_W-1:0] value;
    } cap_evt_t;

    // Low divider bits that must all be one for a tick.
    function automatic logic [DIV_W-1:0] tick_mask(input logic [TSEL_W-1:0] sel);
        logic [DIV_W-1:0] m;
        case (sel)
            3'd0:    m = 10'h000;
            3'd1:    m = 10'h003;
            3'd2:    m = 10'h00F;
            3'd3:    m = 10'h03F;
            3'd4:    m = 10'h0FF;
            default: m = 10'h3FF;
        endcase
        return m;
    endfunction

    // Number of position changes per capture.
    function automatic logic [CHG_W-1:0] span_len(input logic [SSEL_W-1:0] sel);
        logic [CHG_W-1:0] n;
        case (sel)
            2'b01:   n = 3'd3;
            2'b10:   n = 3'd6;
            default: n = 3'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/hst_prescaler.sv
module hst_prescaler
    import hst_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [TSEL_W-1:0] sel_i,
    output logic              tick_o
);
    logic [DW-1:0] div_q;
    logic [DW-1:0] mask;

    assign mask = DW'(tick_mask(sel_i));

    always_ff @(posedge clk) begin
        if (rst || !run_i) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    assign tick_o = run_i && ((div_q & mask) == mask);

    // R2: the undivided setting ticks on every enabled cycle
    assert_full_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (run_i && sel_i == 3'd0) |-> tick_o);

    // R8: divider held at zero while disabled
    assert_div_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (div_q == '0));
endmodule

// File: rtl/hst_edge_span.sv
module hst_edge_span
    import hst_pkg::*;
#(
    parameter int PW = POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [PW-1:0]     pos_i,
    input  logic [SSEL_W-1:0] span_i,
    output logic              fire_o
);
    logic [PW-1:0]     prev_q;
    logic [SSEL_W-1:0] span_q;
    logic [CHG_W-1:0]  chg_q;
    logic [CHG_W-1:0]  need;
    logic              moved;
    logic              resync;

    assign need   = span_len(span_i);
    assign moved  = (pos_i != prev_q);
    assign resync = !run_i || (span_i != span_q);
    assign fire_o = !resync && moved && (chg_q == need - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            span_q <= '0;
        end else begin
            prev_q <= pos_i;
            span_q <= span_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || resync)  chg_q <= '0;
        else if (fire_o)    chg_q <= '0;
        else if (moved)     chg_q <= chg_q + 1'b1;
    end

    // R3: partial count never reaches the span length
    assert_chg_bound_R3: assert property (@(posedge clk) disable iff (rst)
        chg_q < span_len(span_q));

    // R7: a select change discards progress
    assert_span_flush_R7: assert property (@(posedge clk) disable iff (rst)
        (span_i != span_q) |=> (chg_q == '0));
endmodule

// File: rtl/hst_period_ctr.sv
module hst_period_ctr
    import hst_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i)              cnt_q <= '0;
        else if (clr_i)                 cnt_q <= '0;
        else if (tick_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i)                        ovf_q <= 1'b0;
        else if (clr_i)                           ovf_q <= 1'b0;
        else if (tick_i && cnt_q == TOP - 1'b1)   ovf_q <= 1'b1;
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R6: saturated counter holds until cleared
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (run_i && !clr_i && cnt_q == TOP) |=> (cnt_q == TOP));

    // R6: flag only stands on a saturated counter
    assert_ovf_sat_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (cnt_q == TOP));

    // R8: counter idle while disabled
    assert_cnt_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/hall_speed_timer.sv
module hall_speed_timer
    import hst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [2:0]  hall_pos,
    input  logic [2:0]  tick_sel,
    input  logic [1:0]  span_sel,
    output logic [15:0] cap_value,
    output logic        cap_valid,
    output logic        ovf,
    output logic        irq
);
    logic             tick;
    logic             fire;
    logic [CNT_W-1:0] cnt;
    cap_evt_t         evt;
    logic [CNT_W-1:0] cap_q;
    logic             valid_q;
    logic             irq_q;

    hst_prescaler #(.DW(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .run_i (en),
        .sel_i (tick_sel),
        .tick_o(tick)
    );

    hst_edge_span #(.PW(POS_W)) u_span (
        .clk   (clk),
        .rst   (rst),
        .run_i (en),
        .pos_i (hall_pos),
        .span_i(span_sel),
        .fire_o(fire)
    );

    hst_period_ctr #(.CW(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .run_i (en),
        .tick_i(tick),
        .clr_i (fire),
        .cnt_o (cnt),
        .ovf_o (ovf)
    );

    assign evt = '{fire: fire, value: cnt};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= '0;
            valid_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= evt.fire;
            if (evt.fire) begin
                cap_q   <= evt.value;
                valid_q <= 1'b1;
            end
        end
    end

    assign cap_value = cap_q;
    assign cap_valid = valid_q;
    assign irq       = irq_q;

    // R5: an interrupt implies a loaded capture
    assert_irq_valid_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> cap_valid);

    // R4: valid flag is sticky
    assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> cap_valid);

    // R8: no interrupt follows a disabled cycle
    assert_quiet_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq);

    // R4: capture register only moves with an interrupt
    assert_cap_moves_R4: assert property (@(posedge clk) disable iff (rst)
        !irq |-> $stable(cap_value) || $past(rst));
endmodule

// File: tb/hall_speed_timer_bench.sv
module hall_speed_timer_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [2:0]  hall_pos;
    logic [2:0]  tick_sel;
    logic [1:0]  span_sel;
    logic [15:0] cap_value;
    logic        cap_valid;
    logic        ovf;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    int pidx  = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hall_speed_timer u_hall_speed_timer (
        .clk(clk), .rst(rst), .en(en), .hall_pos(hall_pos),
        .tick_sel(tick_sel), .span_sel(span_sel),
        .cap_value(cap_value), .cap_valid(cap_valid), .ovf(ovf), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic move();
        logic [2:0] seq [6] = '{3'd1, 3'd3, 3'd2, 3'd6, 3'd4, 3'd5};
        pidx     = (pidx + 1) % 6;
        hall_pos = seq[pidx];
    endtask

    task automatic idle();
        en = 1'b0;
        run(2);
    endtask

    task automatic t_reset();
        chk("R1", "cap_value", cap_value, 16'h0);
        chk("R1", "cap_valid", {15'd0, cap_valid}, 16'h0);
        chk("R1", "ovf", {15'd0, ovf}, 16'h0);
        chk("R1", "irq", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_basic();
        idle(); tick_sel = 3'd0; span_sel = 2'b00; run(1);
        en = 1'b1;
        run(10); move(); run(1);
        chk("R4", "first capture", cap_value, 16'd10);
        chk("R5", "irq on capture", {15'd0, irq}, 16'd1);
        chk("R4", "valid set", {15'd0, cap_valid}, 16'd1);
        run(1);
        chk("R5", "irq single cycle", {15'd0, irq}, 16'd0);
        run(4); move(); run(1);
        chk("R4", "counter restarted", cap_value, 16'd5);
    endtask

    task automatic t_prescale();
        int divs [7] = '{1, 4, 16, 64, 256, 1024, 1024};
        logic [2:0] codes [7] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7};
        for (int i = 0; i < 7; i++) begin
            idle(); tick_sel = codes[i]; span_sel = 2'b00; run(1);
            en = 1'b1;
            run(10 * divs[i]); move(); run(1);
            chk("R2", $sformatf("ten ticks code %0d", codes[i]), cap_value, 16'd10);
        end
    endtask

    task automatic t_span(input logic [1:0] code, input int m);
        idle(); tick_sel = 3'd0; span_sel = code; run(1);
        en = 1'b1;
        run(4);
        for (int k = 0; k < m - 1; k++) begin
            move(); run(1);
            chk("R3", $sformatf("no irq at change %0d of %0d", k + 1, m), {15'd0, irq}, 16'd0);
            run(3);
        end
        move(); run(1);
        chk("R3", $sformatf("irq at change %0d", m), {15'd0, irq}, 16'd1);
        chk("R3", $sformatf("capture span %0d", m), cap_value, 16'(4 * m));
    endtask

    task automatic t_span_reset();
        idle(); tick_sel = 3'd0; span_sel = 2'b01; run(1);
        en = 1'b1;
        run(2); move(); run(2); move(); run(2);
        span_sel = 2'b10; run(1);
        span_sel = 2'b01; run(1);
        move(); run(1);
        chk("R7", "count flushed, first new change", {15'd0, irq}, 16'd0);
        run(1); move(); run(1);
        chk("R7", "count flushed, second new change", {15'd0, irq}, 16'd0);
        run(1); move(); run(1);
        chk("R7", "third new change captures", {15'd0, irq}, 16'd1);
    endtask

    task automatic t_alias();
        idle(); tick_sel = 3'd0; span_sel = 2'b11; run(1);
        en = 1'b1;
        run(3); move(); run(1);
        chk("R3", "code 11 captures each change", {15'd0, irq}, 16'd1);
        chk("R3", "code 11 value", cap_value, 16'd3);
        run(2); move(); run(1);
        chk("R3", "code 11 next change", cap_value, 16'd2);
    endtask

    task automatic t_disable();
        en = 1'b0; run(1);
        move(); run(2);
        chk("R8", "no irq while off", {15'd0, irq}, 16'd0);
        move(); run(2);
        chk("R8", "capture held", cap_value, 16'd2);
        chk("R8", "valid held", {15'd0, cap_valid}, 16'd1);
        en = 1'b1;
        run(3); move(); run(1);
        chk("R8", "counter restarted from zero", cap_value, 16'd3);
    endtask

    task automatic t_overflow();
        idle(); tick_sel = 3'd0; span_sel = 2'b00; run(1);
        en = 1'b1;
        run(65534);
        chk("R6", "ovf before saturation", {15'd0, ovf}, 16'd0);
        run(1);
        chk("R6", "ovf at saturation", {15'd0, ovf}, 16'd1);
        run(20);
        chk("R6", "ovf sticky", {15'd0, ovf}, 16'd1);
        move(); run(1);
        chk("R6", "saturated capture", cap_value, 16'hFFFF);
        chk("R6", "ovf cleared by capture", {15'd0, ovf}, 16'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; en = 1'b0; hall_pos = 3'd1; tick_sel = 3'd0; span_sel = 2'b00;
        run(4);
        rst = 1'b0;
        run(1);
        t_reset();
        t_basic();
        t_prescale();
        t_span(2'b01, 3);
        t_span(2'b10, 6);
        t_span_reset();
        t_alias();
        t_disable();
        t_overflow();
        finish_run();
    end
endmodule